// File: doc/BRIEF.md
# Serial Wire Debug Target Engine

This block is the target end of a two-wire synchronous debug link. The host supplies a bit clock and shares one data line with the target. The line is presented to the block as a separate input, output and output-enable. Each transaction runs in three phases: an 8-bit request from the host, a 3-bit acknowledge from the target, and a 33-bit data phase. The data phase carries 32 data bits and an even-parity bit, and it is driven by whichever side supplies the data. Every field travels least significant bit first. The host clock and data are resynchronised into a faster system clock, and all state advances on detected rising edges of the host clock.

A request addresses one of two banks. The debug-port bank is held locally: a control/status word, a select word and a read buffer. Access-port traffic is handed to a single-outstanding parallel request/response port. The select word chooses the access port and the four-word window on it. Access-port reads are posted, so each one returns the result of the previous access-port read. The read buffer lets the host fetch the most recent result without starting another access.

Top module: `swd_target`

## Requirements
- R1: After reset the line is undriven (`swdio_oe`=0), no access-port request is raised, `ap_sel` and `ap_bank` are zero, and the select word and read buffer both read as zero.
- R2: The request byte is bit0 start=1, bit1 bank (1=access port), bit2 read (1=read), bit3 A[2], bit4 A[3], bit5 even parity over bits 1..4, bit6 stop=0, bit7 park=1. A well-formed request is answered after exactly one turnaround bit with a 3-bit acknowledge sent LSB-first: OK=3'b001, WAIT=3'b010, FAULT=3'b100.
- R3: A request with stop=1, park=0 or a parity mismatch gets no acknowledge. The target never drives the line for it and raises no access-port request, and the next well-formed request is served normally.
- R4: After an OK to a read, the target drives 32 data bits LSB-first and then one bit that makes the 33-bit group even parity.
- R5: Debug-port decode uses A[3:2]. Code 00 is reserved: it reads as zero and writes to it are ignored. Code 01 is control/status, 10 is select and 11 is the read buffer. Select keeps bits 31:24 (port selector) and 7:4 (window selector), and bits 23:8 and 3:0 read as zero.
- R6: An access-port request carries `ap_sel` = select[31:24], `ap_bank` = select[7:4] and `ap_addr` = A[3:2]. A good access-port write raises exactly one write request, carrying the received word, after its data phase.
- R7: An access-port read returns the previous access-port result and latches the new result into the read buffer. A read-buffer read returns that latched value without raising a request.
- R8: While an access-port request is outstanding, control/status bit 6 reads 1. An access-port access or a read-buffer read in that time gets WAIT, with no data phase and no new request.
- R9: A write whose data-phase parity is wrong is discarded and sets a sticky error, control/status bit 7. While the flag is set, access-port accesses get FAULT. A control/status write with bit 7 = 1 clears the flag.
- R10: The output enable is low in every turnaround bit: between request and acknowledge, between acknowledge and write data, and after read data. The output and output enable change only after a host clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the host clock |
| rst | input | 1 | Synchronous active-high reset |
| swclk | input | 1 | Host bit clock (asynchronous) |
| swdio_in | input | 1 | Data line as seen at the pad |
| swdio_out | output | 1 | Value the target drives onto the line |
| swdio_oe | output | 1 | Target drive enable for the line |
| ap_req | output | 1 | One-cycle access-port request strobe |
| ap_write | output | 1 | Request is a write (1) or a read (0) |
| ap_sel | output | 8 | Access-port selector from select word |
| ap_bank | output | 4 | Four-word window selector from select word |
| ap_addr | output | 2 | Word within the window (A[3:2]) |
| ap_wdata | output | 32 | Write data for access-port writes |
| ap_ack | input | 1 | One-cycle completion strobe from the access port |
| ap_rdata | input | 32 | Read result, valid with `ap_ack` |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and a 32-bit word with an 8-bit port selector and a 4-bit window selector. The host clock is driven at one-sixteenth of the system clock, so the edge-to-output delay of the synchroniser falls well inside one host half-period. The bench's access-port model has a latency it sets per test. Short latencies drive the posted-read and back-to-back paths, and one very long latency keeps a request outstanding across several transactions to bring WAIT within reach.

// File: rtl/swd_pkg.sv
package swd_pkg;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam logic [1:0] DP_RSVD  = 2'b00;
  localparam logic [1:0] DP_CTRL  = 2'b01;
  localparam logic [1:0] DP_SEL   = 2'b10;
  localparam logic [1:0] DP_RDBUF = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_TRN_A, ST_ACK, ST_RDATA, ST_TRN_W, ST_WDATA, ST_SKIP
  } link_st_e;

  // start high, stop low, park high, even parity over bank/dir/address
  function automatic logic req_well_formed(input logic [7:0] r);
    return r[0] & ~r[6] & r[7] & ~(^r[5:1]);
  endfunction

endpackage

// File: rtl/swd_edge_sync.sv
module swd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic swclk,
  input  logic swdio_in,
  output logic tick,
  output logic din
);
  logic [STAGES-1:0] clk_sr;
  logic [STAGES-1:0] dio_sr;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr   <= '0;
      dio_sr   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], swclk};
      dio_sr   <= {dio_sr[STAGES-2:0], swdio_in};
      clk_prev <= clk_sr[STAGES-1];
    end
  end

  assign tick = clk_sr[STAGES-1] & ~clk_prev;
  assign din  = dio_sr[STAGES-1];

endmodule

// File: rtl/swd_dp_regs.sv
module swd_dp_regs
  import swd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int APSEL_W = 8,
  parameter int BANK_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dp_wr,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              par_err,
  input  logic              ap_req,
  input  logic              ap_write,
  input  logic              ap_ack,
  input  logic [DATA_W-1:0] ap_rdata,
  input  logic              rd_ap,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic              sticky,
  output logic              ap_busy,
  output logic [APSEL_W-1:0] ap_sel,
  output logic [BANK_W-1:0]  ap_bank
);
  localparam int SEL_LO  = DATA_W - APSEL_W;
  localparam int BANK_LO = 4;
  localparam int ERR_BIT  = 7;
  localparam int BUSY_BIT = 6;
  localparam logic [DATA_W-1:0] SEL_MASK =
    ({{APSEL_W{1'b1}}, {SEL_LO{1'b0}}}) | (DATA_W'({BANK_W{1'b1}}) << BANK_LO);

  logic [DATA_W-1:0] sel_q;
  logic [DATA_W-1:0] rdbuf_q;
  logic              busy_rd;
  logic [DATA_W-1:0] ctrl_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      rdbuf_q <= '0;
      sticky  <= 1'b0;
      ap_busy <= 1'b0;
      busy_rd <= 1'b0;
    end else begin
      if (par_err)
        sticky <= 1'b1;
      else if (dp_wr && wr_addr == DP_CTRL && wr_data[ERR_BIT])
        sticky <= 1'b0;
      if (dp_wr && wr_addr == DP_SEL)
        sel_q <= wr_data & SEL_MASK;
      if (ap_req) begin
        ap_busy <= 1'b1;
        busy_rd <= ~ap_write;
      end else if (ap_ack && ap_busy) begin
        ap_busy <= 1'b0;
        if (busy_rd) rdbuf_q <= ap_rdata;
      end
    end
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[ERR_BIT]  = sticky;
    ctrl_word[BUSY_BIT] = ap_busy;
  end

  always_comb begin
    if (rd_ap) rd_word = rdbuf_q;
    else begin
      case (rd_addr)
        DP_CTRL:  rd_word = ctrl_word;
        DP_SEL:   rd_word = sel_q;
        DP_RDBUF: rd_word = rdbuf_q;
        default:  rd_word = '0;
      endcase
    end
  end

  assign ap_sel  = sel_q[DATA_W-1 -: APSEL_W];
  assign ap_bank = sel_q[BANK_LO +: BANK_W];

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    ap_req |-> !ap_busy);  // R8
  AST_STICKY_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky) |-> $past(par_err));  // R9

endmodule

// File: rtl/swd_link_fsm.sv
module swd_link_fsm
  import swd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              sticky,
  input  logic              ap_busy,
  output logic              acc_ap,
  output logic [1:0]        acc_addr,
  output logic              dout,
  output logic              oe,
  output logic              dp_wr,
  output logic [DATA_W-1:0] wr_data,
  output logic              par_err,
  output logic              ap_req,
  output logic              ap_write
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] REQ_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(3);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(DATA_W + 1);
  localparam logic [2:0]       SKIP_BAD  = 3'd5;

  link_st_e          state;
  logic [CNT_W-1:0]  cnt;
  logic [6:0]        shreq;
  logic [DATA_W-1:0] shdat;
  logic [DATA_W:0]   rsh;
  logic [2:0]        ack_q;
  logic [2:0]        skip;
  logic              acc_rnw;
  logic [7:0]        req_nxt;
  logic [DATA_W:0]   dat_nxt;
  logic [2:0]        ack_sel;
  logic              rdbuf_rd;

  assign req_nxt  = {din, shreq};
  assign dat_nxt  = {din, shdat};
  assign rdbuf_rd = ~acc_ap & acc_rnw & (acc_addr == DP_RDBUF);

  always_comb begin
    if (acc_ap && sticky)                    ack_sel = ACK_FAULT;
    else if ((acc_ap || rdbuf_rd) && ap_busy) ack_sel = ACK_WAIT;
    else                                     ack_sel = ACK_OK;
  end

  always_ff @(posedge clk) begin
    dp_wr   <= 1'b0;
    par_err <= 1'b0;
    ap_req  <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreq    <= '0;
      shdat    <= '0;
      rsh      <= '0;
      ack_q    <= '0;
      skip     <= '0;
      acc_ap   <= 1'b0;
      acc_rnw  <= 1'b0;
      acc_addr <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
      wr_data  <= '0;
      ap_write <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: if (din) begin
          shreq <= 7'b1000000;
          cnt   <= CNT_W'(1);
          state <= ST_REQ;
        end
        ST_REQ: begin
          shreq <= req_nxt[7:1];
          cnt   <= cnt + 1'b1;
          if (cnt == REQ_LAST) begin
            if (req_well_formed(req_nxt)) begin
              acc_ap   <= req_nxt[1];
              acc_rnw  <= req_nxt[2];
              acc_addr <= {req_nxt[4], req_nxt[3]};
              state    <= ST_TRN_A;
            end else begin
              skip  <= SKIP_BAD;
              state <= ST_SKIP;
            end
          end
        end
        ST_TRN_A: begin
          ack_q <= ack_sel;
          oe    <= 1'b1;
          dout  <= ack_sel[0];
          cnt   <= CNT_W'(1);
          state <= ST_ACK;
          if (ack_sel == ACK_OK && acc_rnw) begin
            rsh <= {^rd_word, rd_word};
            if (acc_ap) begin
              ap_req   <= 1'b1;
              ap_write <= 1'b0;
            end
          end
        end
        ST_ACK: begin
          if (cnt != ACK_LAST) begin
            dout <= ack_q[cnt[1:0]];
            cnt  <= cnt + 1'b1;
          end else if (ack_q == ACK_OK && acc_rnw) begin
            dout  <= rsh[0];
            rsh   <= {1'b0, rsh[DATA_W:1]};
            cnt   <= CNT_W'(1);
            state <= ST_RDATA;
          end else if (ack_q == ACK_OK) begin
            oe    <= 1'b0;
            state <= ST_TRN_W;
          end else begin
            oe    <= 1'b0;
            skip  <= 3'd1;
            state <= ST_SKIP;
          end
        end
        ST_RDATA: begin
          if (cnt == RD_LAST) begin
            oe    <= 1'b0;
            skip  <= 3'd1;
            state <= ST_SKIP;
          end else begin
            dout <= rsh[0];
            rsh  <= {1'b0, rsh[DATA_W:1]};
            cnt  <= cnt + 1'b1;
          end
        end
        ST_TRN_W: begin
          cnt   <= '0;
          state <= ST_WDATA;
        end
        ST_WDATA: begin
          shdat <= dat_nxt[DATA_W:1];
          cnt   <= cnt + 1'b1;
          if (cnt == WR_LAST) begin
            state <= ST_IDLE;
            if (~^dat_nxt) begin
              wr_data <= dat_nxt[DATA_W-1:0];
              if (acc_ap) begin
                ap_req   <= 1'b1;
                ap_write <= 1'b1;
              end else begin
                dp_wr <= 1'b1;
              end
            end else begin
              par_err <= 1'b1;
            end
          end
        end
        ST_SKIP: begin
          if (skip == 3'd1) state <= ST_IDLE;
          else              skip  <= skip - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_OE_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe) |-> $past(tick));  // R10
  AST_DOUT_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $past(tick));  // R4
  AST_TRN_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRN_A || state == ST_TRN_W) |-> !oe);  // R10
  AST_AP_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    ap_req |=> !ap_req);  // R6

endmodule

// File: rtl/swd_target.sv
module swd_target #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int APSEL_W     = 8,
  parameter int BANK_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               swclk,
  input  logic               swdio_in,
  output logic               swdio_out,
  output logic               swdio_oe,
  output logic               ap_req,
  output logic               ap_write,
  output logic [APSEL_W-1:0] ap_sel,
  output logic [BANK_W-1:0]  ap_bank,
  output logic [1:0]         ap_addr,
  output logic [DATA_W-1:0]  ap_wdata,
  input  logic               ap_ack,
  input  logic [DATA_W-1:0]  ap_rdata
);
  logic              tick;
  logic              din;
  logic [DATA_W-1:0] rd_word;
  logic              sticky;
  logic              ap_busy;
  logic              acc_ap;
  logic [1:0]        acc_addr;
  logic              dp_wr;
  logic [DATA_W-1:0] wr_data;
  logic              par_err;

  swd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .swclk(swclk), .swdio_in(swdio_in),
    .tick(tick), .din(din)
  );

  swd_link_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .din(din),
    .rd_word(rd_word), .sticky(sticky), .ap_busy(ap_busy),
    .acc_ap(acc_ap), .acc_addr(acc_addr),
    .dout(swdio_out), .oe(swdio_oe),
    .dp_wr(dp_wr), .wr_data(wr_data), .par_err(par_err),
    .ap_req(ap_req), .ap_write(ap_write)
  );

  swd_dp_regs #(.DATA_W(DATA_W), .APSEL_W(APSEL_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst),
    .dp_wr(dp_wr), .wr_addr(acc_addr), .wr_data(wr_data), .par_err(par_err),
    .ap_req(ap_req), .ap_write(ap_write), .ap_ack(ap_ack), .ap_rdata(ap_rdata),
    .rd_ap(acc_ap), .rd_addr(acc_addr), .rd_word(rd_word),
    .sticky(sticky), .ap_busy(ap_busy), .ap_sel(ap_sel), .ap_bank(ap_bank)
  );

  assign ap_addr  = acc_addr;
  assign ap_wdata = wr_data;

endmodule

// File: tb/sim_swd_target.sv
module sim_swd_target;
  localparam int HALF = 8;
  localparam logic [2:0] OK = 3'b001, WT = 3'b010, FL = 3'b100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic swclk = 1'b0, host_en = 1'b0, host_val = 1'b0;
  logic line;
  logic swdio_out, swdio_oe, ap_req, ap_write, ap_ack;
  logic [7:0] ap_sel;
  logic [3:0] ap_bank;
  logic [1:0] ap_addr;
  logic [31:0] ap_wdata, ap_rdata;

  always_comb line = swdio_oe ? swdio_out : (host_en ? host_val : 1'b1);

  swd_target u0 (
    .clk(clk), .rst(rst), .swclk(swclk), .swdio_in(line),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe),
    .ap_req(ap_req), .ap_write(ap_write), .ap_sel(ap_sel), .ap_bank(ap_bank),
    .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_ack(ap_ack), .ap_rdata(ap_rdata)
  );

  // access-port model
  logic [31:0] mem [64];
  int          ap_lat = 10;
  int          busy_cnt;
  int          ap_cnt;
  logic        cap_write;
  logic [5:0]  cap_idx;
  logic [31:0] cap_wdata, pend;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h9E3779B9 * (i + 1);
      busy_cnt <= 0; ap_cnt <= 0; ap_ack <= 1'b0; ap_rdata <= '0;
      cap_write <= 1'b0; cap_idx <= '0; cap_wdata <= '0; pend <= '0;
    end else begin
      ap_ack <= 1'b0;
      if (ap_req) begin
        ap_cnt    <= ap_cnt + 1;
        cap_write <= ap_write;
        cap_idx   <= {ap_sel[1:0], ap_bank[1:0], ap_addr};
        cap_wdata <= ap_wdata;
        pend      <= mem[{ap_sel[1:0], ap_bank[1:0], ap_addr}];
        if (ap_write) mem[{ap_sel[1:0], ap_bank[1:0], ap_addr}] <= ap_wdata;
        busy_cnt  <= ap_lat;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) begin ap_ack <= 1'b1; ap_rdata <= pend; end
      end
    end
  end

  int n_chk = 0, n_err = 0;
  logic done = 1'b0;
  logic [31:0] exp_sel = '0, exp_rdbuf = '0;
  logic exp_sticky = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_dp(input logic [1:0] a);
    case (a)
      2'b01:   return {24'b0, exp_sticky, (busy_cnt != 0), 6'b0};
      2'b10:   return exp_sel;
      2'b11:   return exp_rdbuf;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [5:0] sel_idx(input logic [1:0] a);
    return {exp_sel[25:24], exp_sel[5:4], a};
  endfunction

  logic b_smp, b_oe, contention = 1'b0;
  task automatic bit_period(input logic en, input logic val);
    host_en = en; host_val = val;
    repeat (HALF) @(negedge clk);
    b_smp = line; b_oe = swdio_oe;
    if (en && swdio_oe) contention = 1'b1;
    swclk = 1'b1;
    repeat (HALF) @(negedge clk);
    swclk = 1'b0;
  endtask

  logic [2:0]  t_ack;
  logic [31:0] t_rdata;
  logic        t_rpar_ok, t_trn_err, t_oe_any;

  // bad: 0 none, 1 stop high, 2 park low, 3 parity flipped
  task automatic txn(input logic ap, input logic rnw, input logic [1:0] a,
                     input logic [31:0] wd, input int bad, input logic bad_wpar);
    logic [7:0] rq;
    logic [32:0] rd;
    rq = {1'b1, 1'b0, ^{ap, rnw, a}, a[1], a[0], rnw, ap, 1'b1};
    if (bad == 1) rq[6] = 1'b1;
    if (bad == 2) rq[7] = 1'b0;
    if (bad == 3) rq[5] = ~rq[5];
    t_trn_err = 1'b0; t_oe_any = 1'b0; t_rdata = '0; t_rpar_ok = 1'b1;
    for (int i = 0; i < 8; i++) bit_period(1'b1, rq[i]);
    bit_period(1'b0, 1'b0);
    if (b_oe) t_trn_err = 1'b1;
    for (int i = 0; i < 3; i++) begin
      bit_period(1'b0, 1'b0);
      t_ack[i] = b_smp;
      if (b_oe) t_oe_any = 1'b1;
    end
    if (t_ack == OK && rnw) begin
      for (int i = 0; i < 33; i++) begin bit_period(1'b0, 1'b0); rd[i] = b_smp; end
      t_rdata = rd[31:0]; t_rpar_ok = ~^rd;
      bit_period(1'b0, 1'b0);
      if (b_oe) t_trn_err = 1'b1;
    end else if (t_ack == OK) begin
      bit_period(1'b0, 1'b0);
      if (b_oe) t_trn_err = 1'b1;
      for (int i = 0; i < 32; i++) bit_period(1'b1, wd[i]);
      bit_period(1'b1, (^wd) ^ bad_wpar);
    end else begin
      bit_period(1'b0, 1'b0);
      if (b_oe) t_trn_err = 1'b1;
    end
    for (int i = 0; i < 2; i++) bit_period(1'b1, 1'b0);
  endtask

  task automatic dp_read_chk(input logic [1:0] a, input string req);
    logic [31:0] e;
    e = exp_dp(a);
    txn(1'b0, 1'b1, a, 32'h0, 0, 1'b0);
    chk({req, " ack"}, {29'b0, t_ack}, {29'b0, OK});
    chk({req, " data"}, t_rdata, e);
    chk("R4 read parity", {31'b0, t_rpar_ok}, 32'h1);
    chk("R10 turnaround", {31'b0, t_trn_err}, 32'h0);
  endtask

  task automatic dp_write(input logic [1:0] a, input logic [31:0] wd);
    txn(1'b0, 1'b0, a, wd, 0, 1'b0);
    chk("R2 dp write ack", {29'b0, t_ack}, {29'b0, OK});
    chk("R10 turnaround", {31'b0, t_trn_err}, 32'h0);
    if (a == 2'b10) exp_sel = wd & 32'hFF0000F0;
    if (a == 2'b01 && wd[7]) exp_sticky = 1'b0;
  endtask

  task automatic ap_read_chk(input logic [1:0] a, input string req);
    logic [5:0] idx;
    logic [31:0] nxt;
    int c0;
    idx = sel_idx(a); nxt = mem[idx]; c0 = ap_cnt;
    txn(1'b1, 1'b1, a, 32'h0, 0, 1'b0);
    chk({req, " ack"}, {29'b0, t_ack}, {29'b0, OK});
    chk({req, " posted data"}, t_rdata, exp_rdbuf);
    chk("R4 read parity", {31'b0, t_rpar_ok}, 32'h1);
    chk("R6 read request count", ap_cnt, c0 + 1);
    chk("R6 read request fields", {25'b0, cap_write, cap_idx}, {25'b0, 1'b0, idx});
    exp_rdbuf = nxt;
  endtask

  task automatic ap_write_chk(input logic [1:0] a, input logic [31:0] wd);
    logic [5:0] idx;
    int c0;
    idx = sel_idx(a); c0 = ap_cnt;
    txn(1'b1, 1'b0, a, wd, 0, 1'b0);
    chk("R6 write ack", {29'b0, t_ack}, {29'b0, OK});
    repeat (4) @(negedge clk);
    chk("R6 write request count", ap_cnt, c0 + 1);
    chk("R6 write fields", {25'b0, cap_write, cap_idx}, {25'b0, 1'b1, idx});
    chk("R6 write data", cap_wdata, wd);
    while (busy_cnt != 0) @(negedge clk);
  endtask

  initial begin
    int c0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {31'b0, swdio_oe}, 32'h0);
    chk("R1 ap_req", {31'b0, ap_req}, 32'h0);
    chk("R1 sel/bank", {20'b0, ap_sel, ap_bank}, 32'h0);
    dp_read_chk(2'b10, "R1 select after reset");
    dp_read_chk(2'b11, "R1 rdbuf after reset");
    // R5 select masking, R6 outputs
    dp_write(2'b10, 32'h12345678);
    chk("R6 ap_sel", {24'b0, ap_sel}, 32'h12);
    chk("R6 ap_bank", {28'b0, ap_bank}, 32'h7);
    dp_read_chk(2'b10, "R5 select masked");
    dp_write(2'b00, 32'hFFFFFFFF);
    dp_read_chk(2'b00, "R5 reserved reads zero");
    dp_read_chk(2'b10, "R5 select unchanged by reserved write");
    // R3 malformed requests
    for (int k = 1; k <= 3; k++) begin
      c0 = ap_cnt;
      txn(1'b1, 1'b1, 2'b01, 32'h0, k, 1'b0);
      chk("R3 no ack", {29'b0, t_ack}, 32'h7);
      chk("R3 never driven", {31'b0, t_oe_any | t_trn_err}, 32'h0);
      chk("R3 no request", ap_cnt, c0);
      dp_read_chk(2'b10, "R3 next request served");
    end
    // R7 posted reads
    dp_write(2'b10, 32'h01000020);
    ap_lat = 10;
    ap_read_chk(2'b01, "R7 first");
    ap_read_chk(2'b10, "R7 second");
    c0 = ap_cnt;
    dp_read_chk(2'b11, "R7 rdbuf");
    chk("R7 rdbuf no request", ap_cnt, c0);
    // R8 WAIT
    ap_lat = 3000;
    ap_read_chk(2'b11, "R8 issue");
    exp_rdbuf = 32'h0; // placeholder restored below
    dp_read_chk(2'b01, "R8 busy bit");
    c0 = ap_cnt;
    txn(1'b1, 1'b1, 2'b00, 32'h0, 0, 1'b0);
    chk("R8 ap wait", {29'b0, t_ack}, {29'b0, WT});
    txn(1'b0, 1'b1, 2'b11, 32'h0, 0, 1'b0);
    chk("R8 rdbuf wait", {29'b0, t_ack}, {29'b0, WT});
    chk("R8 no request", ap_cnt, c0);
    while (busy_cnt != 0) @(negedge clk);
    exp_rdbuf = mem[sel_idx(2'b11)];
    dp_read_chk(2'b11, "R8 rdbuf after wait");
    ap_lat = 10;
    // R9 write parity error
    txn(1'b0, 1'b0, 2'b10, 32'hAB0000C0, 0, 1'b1);
    chk("R9 ack before parity", {29'b0, t_ack}, {29'b0, OK});
    exp_sticky = 1'b1;
    dp_read_chk(2'b10, "R9 select unchanged");
    dp_read_chk(2'b01, "R9 sticky set");
    c0 = ap_cnt;
    txn(1'b1, 1'b1, 2'b00, 32'h0, 0, 1'b0);
    chk("R9 fault", {29'b0, t_ack}, {29'b0, FL});
    chk("R9 no request on fault", ap_cnt, c0);
    dp_write(2'b01, 32'h00000080);
    dp_read_chk(2'b01, "R9 sticky cleared");
    c0 = ap_cnt;
    txn(1'b1, 1'b0, 2'b01, 32'h5555AAAA, 0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 bad ap write discarded", ap_cnt, c0);
    exp_sticky = 1'b1;
    dp_read_chk(2'b01, "R9 sticky from ap write");
    dp_write(2'b01, 32'h00000080);
    ap_write_chk(2'b01, 32'hCAFE0123);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int op;
      logic [1:0] a;
      logic [31:0] d;
      op = $urandom % 6; a = 2'($urandom); d = $urandom;
      ap_lat = 1 + ($urandom % 30);
      case (op)
        0: dp_write(2'b10, d);
        1: dp_read_chk(a, "R5 random dp read");
        2: ap_read_chk(a, "R7 random ap read");
        3: ap_write_chk(a, d);
        4: dp_write(2'b00, d);
        default: begin
          c0 = ap_cnt;
          dp_read_chk(2'b11, "R7 random rdbuf");
          chk("R7 rdbuf no request", ap_cnt, c0);
        end
      endcase
    end
    chk("R10 no contention", {31'b0, contention}, 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule